// File: doc/BRIEF.md
# Multi-Die Asynchronous SRAM Controller

This block is a clocked host-side controller for an asynchronous static memory module made of several dies. All dies share one address bus, one data bus, one write strobe and one output-enable line. Each die has its own active-low enable. The host issues single-word reads and writes over a valid/ready handshake. The controller splits the host address into a die number and a word address, and turns the die number into exactly one enable. It then steps the memory pins through address settle, strobe and recovery phases. Every phase length is derived from a nanosecond figure and the clock period.

After reset the controller holds off all traffic for a start-up period, 100 ms by default. This gives the memory's internal power-on circuit time to finish. The address is presented with every enable high, and an enable drops only after the address has been stable for at least one settle phase. This avoids a spurious extra internal read caused by skew between address and enable edges. The data drivers are on only while the output-enable line is high, so the host and the memory never drive the bus at the same time.

Only one operation is in flight at a time. Read data is captured in the last cycle of the access and returned with a single-cycle valid pulse.

Top module: `msram_ctrl`

## Requirements
- R1: `req_ready` stays low for at least ceil(STARTUP_NS/CLK_NS) cycles after reset is released, then rises. No memory enable falls during that time.
- R2: At most one bit of `mem_ce_n` is low in any cycle, and all bits are high in reset and whenever no access is in progress.
- R3: The die is selected by the host address bits above bit ADDR_W-1, and die i drives `mem_ce_n[i]`. `mem_addr` carries the low ADDR_W bits of the accepted address.
- R4: A write holds the die enable and `mem_we_n` low for ceil(max(8 ns, data setup, 10 ns)/CLK_NS) cycles. Data setup is 6 ns for 8-die builds and 5 ns otherwise. During the strobe `mem_oe_n` is high, `mem_dq_oe` is high and `mem_dq_out` equals the accepted write data.
- R5: A read holds the die enable and `mem_oe_n` low, with `mem_we_n` high, for ceil(T/CLK_NS) cycles. T is 20, 22 or 25 ns for builds of up to 2, up to 4, or more dies. `rsp_valid` is high for exactly one cycle, the cycle after the last strobe cycle. `rsp_rdata` then equals `mem_dq_in` as sampled in that last strobe cycle.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: `mem_addr` is unchanged in the cycle an enable first falls, relative to the previous cycle (in which all enables were high). It also stays unchanged for as long as an enable is low.
- R8: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the operation has finished. A request offered while `req_ready` is low has no effect on the memory.
- R9: After a write strobe ends, `mem_dq_oe` stays high with the same data for one more cycle (data hold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+clog2(NUM_DIES) | Die number (upper bits) and word address (lower bits) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_ce_n | output | NUM_DIES | Per-die enables, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers toward the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Writes go to every die of a four-die build and are then read back. Each die holds a distinct data pattern: all ones, alternating bits and a sparse value. A wrong die decode or a swapped enable therefore returns data that does not match. A write followed at once by a read of the same word checks that the strobe actually stored the data. A read followed by a write exercises the bus turnaround, where output enable and data drive must not overlap. A write offered during the start-up hold-off, then read back as the untouched initial value, shows that requests are ignored while ready is low.

// File: rtl/msram_pkg.sv
`timescale 1ns/1ps
package msram_pkg;

    // Fixed electrical figures of the memory, in nanoseconds
    localparam int WPULSE_NS = 8;   // minimum write strobe
    localparam int WCYCLE_NS = 10;  // minimum write cycle
    localparam int SETTLE_NS = 5;   // address settle before enable (skew margin)

    typedef enum logic [2:0] {
        PH_BOOT,
        PH_IDLE,
        PH_SETUP,
        PH_WRITE,
        PH_READ,
        PH_RECOV
    } phase_e;

    // Pin control decoded from the sequencer phase
    typedef struct packed {
        logic sel;    // selected die enable asserted
        logic we_n;
        logic oe_n;
        logic drive;  // host drives data bus
    } pin_ctl_t;

    function automatic int cycles_for(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int read_ns(input int dies);
        if (dies <= 2) return 20;
        if (dies <= 4) return 22;
        return 25;
    endfunction

    function automatic int dsetup_ns(input int dies);
        return (dies >= 8) ? 6 : 5;
    endfunction

    function automatic int write_cycles(input int dies, input int clk_ns);
        int w;
        w = WPULSE_NS;
        if (dsetup_ns(dies) > w) w = dsetup_ns(dies);
        if (WCYCLE_NS > w) w = WCYCLE_NS;
        return cycles_for(w, clk_ns);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/msram_boot.sv
`timescale 1ns/1ps
module msram_boot #(
    parameter int BOOT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CW = $clog2(BOOT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(BOOT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == LAST) done <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/msram_die_dec.sv
`timescale 1ns/1ps
module msram_die_dec #(
    parameter int NUM_DIES = 2,
    parameter int DIE_W    = 1
) (
    input  logic [DIE_W-1:0]    die,
    input  logic                en,
    output logic [NUM_DIES-1:0] ce_n
);
    for (genvar i = 0; i < NUM_DIES; i++) begin : g_die
        assign ce_n[i] = !(en && (die == DIE_W'(i)));
    end
endmodule

// File: rtl/msram_seq.sv
`timescale 1ns/1ps
module msram_seq
    import msram_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int WR_CYC    = 1,
    parameter int RD_CYC    = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     boot_done,
    input  logic     start,
    input  logic     start_wr,
    output logic     ready,
    output logic     capture,
    output logic     rsp_pulse,
    output pin_ctl_t ctl
);
    localparam int MAXC = max3(SETUP_CYC, WR_CYC, RD_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_BOOT;
            cnt       <= '0;
            wr        <= 1'b0;
            rsp_pulse <= 1'b0;
        end else begin
            rsp_pulse <= 1'b0;
            unique case (ph)
                PH_BOOT: if (boot_done) ph <= PH_IDLE;
                PH_IDLE: if (start) begin
                    ph  <= PH_SETUP;
                    cnt <= CW'(SETUP_CYC - 1);
                    wr  <= start_wr;
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= wr ? PH_WRITE : PH_READ;
                        cnt <= wr ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WRITE: begin
                    if (cnt == '0) ph  <= PH_RECOV;
                    else           cnt <= cnt - 1'b1;
                end
                PH_READ: begin
                    if (cnt == '0) begin
                        ph        <= PH_RECOV;
                        rsp_pulse <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: ph <= PH_IDLE;
                default:  ph <= PH_BOOT;
            endcase
        end
    end

    assign ready   = (ph == PH_IDLE);
    assign capture = (ph == PH_READ) && (cnt == '0);

    always_comb begin
        ctl = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        unique case (ph)
            PH_SETUP: ctl.drive = wr;
            PH_WRITE: begin
                ctl.sel   = 1'b1;
                ctl.we_n  = 1'b0;
                ctl.drive = 1'b1;
            end
            PH_READ: begin
                ctl.sel  = 1'b1;
                ctl.oe_n = 1'b0;
            end
            PH_RECOV: ctl.drive = wr;
            default: ;
        endcase
    end
endmodule

// File: rtl/msram_ctrl.sv
`timescale 1ns/1ps
module msram_ctrl
    import msram_pkg::*;
#(
    parameter int NUM_DIES   = 2,
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 39,
    parameter int CLK_NS     = 10,
    parameter int STARTUP_NS = 100_000_000
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic                                   req_write,
    input  logic [ADDR_W+$clog2(NUM_DIES)-1:0]     req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   rsp_valid,
    output logic [DATA_W-1:0]                      rsp_rdata,
    output logic [ADDR_W-1:0]                      mem_addr,
    output logic [NUM_DIES-1:0]                    mem_ce_n,
    output logic                                   mem_we_n,
    output logic                                   mem_oe_n,
    output logic [DATA_W-1:0]                      mem_dq_out,
    output logic                                   mem_dq_oe,
    input  logic [DATA_W-1:0]                      mem_dq_in
);
    localparam int DIE_W     = $clog2(NUM_DIES);
    localparam int HADDR_W   = ADDR_W + DIE_W;
    localparam int BOOT_CYC  = cycles_for(STARTUP_NS, CLK_NS);
    localparam int SETUP_CYC = cycles_for(SETTLE_NS, CLK_NS);
    localparam int WR_CYC    = write_cycles(NUM_DIES, CLK_NS);
    localparam int RD_CYC    = cycles_for(read_ns(NUM_DIES), CLK_NS);

    logic              boot_done;
    logic              start;
    logic              capture;
    pin_ctl_t          ctl;
    logic [ADDR_W-1:0] op_addr;
    logic [DIE_W-1:0]  op_die;
    logic [DATA_W-1:0] op_data;

    msram_boot #(.BOOT_CYC(BOOT_CYC)) i_boot (
        .clk  (clk),
        .rst  (rst),
        .done (boot_done)
    );

    assign start = req_valid && req_ready;

    msram_seq #(
        .SETUP_CYC (SETUP_CYC),
        .WR_CYC    (WR_CYC),
        .RD_CYC    (RD_CYC)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .boot_done (boot_done),
        .start     (start),
        .start_wr  (req_write),
        .ready     (req_ready),
        .capture   (capture),
        .rsp_pulse (rsp_valid),
        .ctl       (ctl)
    );

    // Operation registers: address and data are held for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            op_addr   <= '0;
            op_die    <= '0;
            op_data   <= '0;
            rsp_rdata <= '0;
        end else begin
            if (start) begin
                op_addr <= req_addr[ADDR_W-1:0];
                op_die  <= req_addr[HADDR_W-1:ADDR_W];
                op_data <= req_wdata;
            end
            if (capture) rsp_rdata <= mem_dq_in;
        end
    end

    msram_die_dec #(.NUM_DIES(NUM_DIES), .DIE_W(DIE_W)) i_dec (
        .die  (op_die),
        .en   (ctl.sel),
        .ce_n (mem_ce_n)
    );

    assign mem_addr   = op_addr;
    assign mem_we_n   = ctl.we_n;
    assign mem_oe_n   = ctl.oe_n;
    assign mem_dq_oe  = ctl.drive;
    assign mem_dq_out = op_data;
endmodule

// File: rtl/msram_ctrl_chk.sv
`timescale 1ns/1ps
module msram_ctrl_chk
    import msram_pkg::*;
#(
    parameter int NUM_DIES   = 2,
    parameter int ADDR_W     = 19,
    parameter int CLK_NS     = 10,
    parameter int STARTUP_NS = 100_000_000
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [NUM_DIES-1:0] mem_ce_n,
    input logic                mem_we_n,
    input logic                mem_oe_n,
    input logic                mem_dq_oe
);
    localparam int BOOT_CYC = cycles_for(STARTUP_NS, CLK_NS);
    localparam int WR_CYC   = write_cycles(NUM_DIES, CLK_NS);
    localparam int RD_CYC   = cycles_for(read_ns(NUM_DIES), CLK_NS);

    logic [31:0] since_rst;
    logic [15:0] we_low;
    logic [15:0] oe_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            we_low    <= '0;
            oe_low    <= '0;
        end else begin
            if (since_rst < 32'(BOOT_CYC)) since_rst <= since_rst + 1'b1;
            we_low <= mem_we_n ? '0 : ((we_low == 16'hFFFF) ? we_low : we_low + 1'b1);
            oe_low <= mem_oe_n ? '0 : ((oe_low == 16'hFFFF) ? oe_low : oe_low + 1'b1);
        end
    end

    a_r1_no_ready_in_boot: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 32'(BOOT_CYC)) |-> (!req_ready && (&mem_ce_n)));

    a_r2_one_die: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_ce_n));

    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&mem_ce_n));

    a_r4_strobe_ctl: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_dq_oe && mem_oe_n && !(&mem_ce_n)));

    a_r4_wp_min: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low >= 16'(WR_CYC)));

    a_r5_rd_min: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_low >= 16'(RD_CYC)));

    a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oe_n));

    a_r5_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    a_r7_settle: assert property (@(posedge clk) disable iff (rst)
        $fell(&mem_ce_n) |-> $stable(mem_addr));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_ce_n) && $past(!(&mem_ce_n))) |-> $stable(mem_addr));

    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);
endmodule

bind msram_ctrl msram_ctrl_chk #(
    .NUM_DIES   (NUM_DIES),
    .ADDR_W     (ADDR_W),
    .CLK_NS     (CLK_NS),
    .STARTUP_NS (STARTUP_NS)
) i_chk (.*);

// File: tb/test_msram_ctrl.sv
`timescale 1ns/1ps
module test_msram_ctrl;
    localparam int NDIE = 4;
    localparam int AW   = 19;
    localparam int DW   = 39;
    localparam int HW   = 21;
    localparam int BOOT = 100;  // 1000 ns / 10 ns
    localparam int WPC  = 1;    // ceil(10 ns / 10 ns)
    localparam int RDC  = 3;    // ceil(22 ns / 10 ns) for four dies
    localparam int VW   = 1 + HW + DW;

    // {write, {die, word}, data}; for reads the data field is the expected value
    localparam logic [VW-1:0] VEC [8] = '{
        {1'b1, 2'd0, 19'd3,  39'h00_1234_5678},
        {1'b1, 2'd1, 19'd5,  39'h55_AAAA_5555},
        {1'b1, 2'd2, 19'd3,  39'h2A_5555_AAAA},
        {1'b1, 2'd3, 19'd15, 39'h7F_FFFF_FFFF},
        {1'b0, 2'd0, 19'd3,  39'h00_1234_5678},
        {1'b0, 2'd1, 19'd5,  39'h55_AAAA_5555},
        {1'b0, 2'd2, 19'd3,  39'h2A_5555_AAAA},
        {1'b0, 2'd3, 19'd15, 39'h7F_FFFF_FFFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [HW-1:0]   req_addr  = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic [AW-1:0]   mem_addr;
    logic [NDIE-1:0] mem_ce_n;
    logic            mem_we_n;
    logic            mem_oe_n;
    logic [DW-1:0]   mem_dq_out;
    logic            mem_dq_oe;
    logic [DW-1:0]   mem_dq_in;

    msram_ctrl #(
        .NUM_DIES(NDIE), .ADDR_W(AW), .DATA_W(DW), .CLK_NS(10), .STARTUP_NS(1000)
    ) i_msram_ctrl (.*);

    // Behavioural memory: 16 words per die
    logic [DW-1:0] model [NDIE][16];
    int act_die;
    always_comb begin
        act_die = -1;
        for (int i = 0; i < NDIE; i++) if (!mem_ce_n[i]) act_die = i;
    end
    always_comb begin
        if (act_die >= 0 && !mem_oe_n && mem_we_n) mem_dq_in = model[act_die][mem_addr[3:0]];
        else                                       mem_dq_in = '0;
    end

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pin monitor
    int run = 0, n_pulses = 0, n_rsp = 0;
    int v_r2 = 0, v_r6 = 0, v_r7 = 0, v_r4 = 0, rsp_multi = 0;
    int cur_die, cur_we_low, cur_oe_low;
    int last_len, last_die, last_we_low, last_oe_low;
    logic [AW-1:0] cur_addr, last_addr, prev_addr = '0;
    logic [DW-1:0] cur_data, last_data, post_data, rsp_last;
    logic post_drive, prev_rsp = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(~mem_ce_n) > 1) v_r2++;
            if (mem_dq_oe && !mem_oe_n) v_r6++;
            if (act_die >= 0) begin
                if (mem_addr != prev_addr) v_r7++;
                if (run == 0) begin
                    cur_die = act_die; cur_addr = mem_addr; cur_data = mem_dq_out;
                    cur_we_low = 0; cur_oe_low = 0;
                end
                run++;
                if (!mem_we_n) begin
                    cur_we_low++;
                    if (!mem_dq_oe || mem_dq_out != cur_data) v_r4++;
                    if (mem_dq_oe) model[act_die][mem_addr[3:0]] = mem_dq_out;
                end
                if (!mem_oe_n) cur_oe_low++;
            end else if (run > 0) begin
                last_len = run; last_die = cur_die; last_addr = cur_addr;
                last_we_low = cur_we_low; last_oe_low = cur_oe_low; last_data = cur_data;
                post_drive = mem_dq_oe; post_data = mem_dq_out;
                run = 0; n_pulses++;
            end
            if (rsp_valid) begin
                if (prev_rsp) rsp_multi++;
                n_rsp++; rsp_last = rsp_rdata;
            end
            prev_rsp = rsp_valid;
            prev_addr = mem_addr;
        end
    end

    task automatic run_op(input logic wr, input logic [HW-1:0] a, input logic [DW-1:0] d);
        int p0, r0, g;
        @(negedge clk); #1;
        g = 0;
        while (!req_ready && g < 50) begin @(negedge clk); #1; g++; end
        p0 = n_pulses; r0 = n_rsp;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
        g = 0;
        while (n_pulses == p0 && g < 50) begin @(negedge clk); #1; g++; end
        chk(last_die == int'(a[HW-1:AW]), "R3 die select", last_die, a[HW-1:AW]);
        chk(last_addr == a[AW-1:0], "R3 word address", last_addr, a[AW-1:0]);
        if (wr) begin
            chk(last_len == WPC && last_we_low == WPC, "R4 strobe length", last_we_low, WPC);
            chk(last_oe_low == 0, "R4 oe high in write", last_oe_low, 0);
            chk(last_data == d, "R4 write data", last_data, d);
            chk(post_drive && post_data == d, "R9 data hold", {post_drive, post_data}, {1'b1, d});
        end else begin
            chk(last_len == RDC && last_oe_low == RDC, "R5 read strobe length", last_oe_low, RDC);
            chk(last_we_low == 0, "R5 we high in read", last_we_low, 0);
            chk(n_rsp == r0 + 1, "R5 one rsp pulse", n_rsp - r0, 1);
            chk(rsp_last == d, "R5 read data", rsp_last, d);
        end
    endtask

    initial begin
        for (int i = 0; i < NDIE; i++) for (int j = 0; j < 16; j++) model[i][j] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!req_ready, "R1 ready low in reset", req_ready, 0);
        chk(&mem_ce_n, "R2 enables high in reset", mem_ce_n, 4'hF);
        chk(mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R2 pins idle in reset",
            {mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 4'b1100);

        // Release reset and offer a write that must be ignored during start-up
        rst = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = {2'd0, 19'd9}; req_wdata = 39'h01_DEAD_BEEF;
        begin
            int early = 0;
            for (int i = 0; i < BOOT; i++) begin
                @(negedge clk); #1;
                if (req_ready) early++;
            end
            chk(early == 0, "R1 ready held low during start-up", early, 0);
        end
        req_valid = 1'b0;
        chk(n_pulses == 0 && run == 0, "R8 no access during start-up", n_pulses, 0);
        begin
            int g = 0;
            while (!req_ready && g < 5) begin @(negedge clk); #1; g++; end
            chk(req_ready, "R1 ready after start-up", req_ready, 1);
        end

        // Table walk: write every die, then read every die back
        for (int k = 0; k < 8; k++)
            run_op(VEC[k][VW-1], VEC[k][VW-2 -: HW], VEC[k][DW-1:0]);

        // Ignored request left the word untouched
        run_op(1'b0, {2'd0, 19'd9}, 39'h0);
        // Write then immediate read of the same word
        run_op(1'b1, {2'd2, 19'd3}, 39'h13_579B_DF02);
        run_op(1'b0, {2'd2, 19'd3}, 39'h13_579B_DF02);
        // Read then write turnaround on die 1
        run_op(1'b0, {2'd1, 19'd5}, 39'h55_AAAA_5555);
        run_op(1'b1, {2'd1, 19'd5}, 39'h0F_0F0F_0F0F);
        run_op(1'b0, {2'd1, 19'd5}, 39'h0F_0F0F_0F0F);

        @(negedge clk); #1;
        chk(&mem_ce_n, "R2 enables high when idle", mem_ce_n, 4'hF);
        chk(v_r2 == 0, "R2 one-hot enables", v_r2, 0);
        chk(v_r6 == 0, "R6 no bus contention", v_r6, 0);
        chk(v_r7 == 0, "R7 address stable at enable", v_r7, 0);
        chk(v_r4 == 0, "R4 data driven during strobe", v_r4, 0);
        chk(rsp_multi == 0, "R5 rsp single cycle", rsp_multi, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule